// File: doc/BRIEF.md
# USB Device State and Status-Stage Interrupt Control

This block keeps the enumeration state of a USB device controller (Default, Addressed or Configured) and the enable for an interrupt that tells firmware the host has started the status stage of a control read before the device finished its data stage. That happens when the host ends the data phase early with a short length. The block has two byte-wide registers. A local CPU bus selects between them with a single address bit. The protocol engine feeds in three single-cycle events: setup packet received, USB bus reset, and status token seen while the data stage is still open.

Firmware moves the device between Addressed and Configured by writing only the Configured bit. Hardware keeps the other state bits consistent, and the Default bit is derived. Once a state write is accepted, the register ignores further state writes for a short recovery window. Each new setup packet disarms the interrupt enable, so firmware opts in per transfer. The interrupt itself is a sticky pending flag that firmware clears by writing a one to it.

Top module: `usb_devstate_ctl`

## Requirements
- R1: After reset, `dev_state` is 3'b001, `irq` and `wr_busy` are 0, the state register reads 0x01 and the interrupt control register reads 0x00.
- R2: The state register (bus_addr=0) reads {5'b0, Configured, Addressed, Default} in bits 7..0. Exactly one of bits 2..0 is set, and `dev_state` carries the same three bits. Default is never written by software: writing bit 0 has no effect.
- R3: An accepted write to the state register with bit 2 = 1 gives Configured (3'b100) on the next cycle, with Addressed cleared by hardware.
- R4: An accepted write to the state register with bit 2 = 0 gives Addressed (3'b010) on the next cycle, whatever is written to bits 1 and 0.
- R5: A state write is accepted only when `wr_busy` is 0. It raises `wr_busy` for the following LOCK_CYCLES (default 5) cycles. State writes during that window are ignored, and reads still return the current value.
- R6: Bit 0 of the interrupt control register (bus_addr=1) is the status-stage interrupt enable. It is read/write, and reset clears it. Interrupt control writes are never locked out.
- R7: `ev_setup` clears the enable on the next cycle. This wins over a write to the enable in the same cycle.
- R8: When the enable is 1 and `ev_status_early` pulses, the pending flag is set on the next cycle. The flag reads as bit 7 of the interrupt control register, drives `irq`, and stays set until cleared.
- R9: Writing the interrupt control register with bit 7 = 1 clears the pending flag. A qualifying `ev_status_early` in the same cycle wins and leaves it set.
- R10: `ev_bus_reset` forces Default and clears the pending flag on the next cycle, leaving the enable unchanged. It overrides a state write in the same cycle, but an accepted write still starts the lockout window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 1 | Register select: 0 state, 1 interrupt control |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| ev_setup | input | 1 | Setup packet received |
| ev_bus_reset | input | 1 | USB bus reset detected |
| ev_status_early | input | 1 | Status token arrived during the data stage |
| dev_state | output | 3 | One-hot state {Configured, Addressed, Default} |
| wr_busy | output | 1 | State register in write recovery |
| irq | output | 1 | Status-stage interrupt request (pending flag) |

## Verification
The assertions assume that every input has a known value after reset and changes only between clock edges, synchronous to `clk`. They also assume that event inputs may coincide with one another and with bus writes in any combination, since the priority rules are stated for exactly those collisions. The bench draws every input from a seeded `$urandom` at the falling edge, so values are never unknown. It weights events so that setup, bus reset, early-status pulses and writes overlap often, including writes that fall inside the recovery window.

// File: rtl/usb_devstate_pkg.sv
package usb_devstate_pkg;
  localparam int unsigned REG_W       = 8;
  localparam int unsigned ST_W        = 3;
  localparam int unsigned ST_DEF_BIT  = 0;
  localparam int unsigned ST_ADR_BIT  = 1;
  localparam int unsigned ST_CFG_BIT  = 2;
  localparam int unsigned IC_EN_BIT   = 0;
  localparam int unsigned IC_PEND_BIT = 7;

  typedef enum logic [ST_W-1:0] {
    DS_DEFAULT    = 3'b001,
    DS_ADDRESSED  = 3'b010,
    DS_CONFIGURED = 3'b100
  } dev_state_e;

  typedef enum logic {
    SEL_STATE  = 1'b0,
    SEL_INTCTL = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/usb_rst_sync.sv
module usb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  localparam int unsigned SW = (STAGES < 2) ? 2 : STAGES;

  logic [SW-1:0] sync_q;
  logic [SW-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[SW-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign srst_n = sync_q[SW-1];
endmodule

// File: rtl/usb_state_reg.sv
module usb_state_reg
  import usb_devstate_pkg::*;
#(
  parameter int unsigned LOCK_CYCLES = 5
) (
  input  logic            clk,
  input  logic            srst_n,
  input  logic            wr_req,
  input  logic            wr_cfg,
  input  logic            bus_reset,
  output logic [ST_W-1:0] state_o,
  output logic            busy_o
);
  localparam int unsigned CNT_W = $clog2(LOCK_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LOCK_CYCLES);

  logic             cfg_q, cfg_d;
  logic             adr_q, adr_d;
  logic             st_en;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             accept;

  assign busy_o = (cnt_q != '0);
  assign accept = wr_req & ~busy_o;

  // next-state: bus reset dominates, an accepted write picks from bit 2 only
  always_comb begin
    st_en = bus_reset | accept;
    cfg_d = cfg_q;
    adr_d = adr_q;
    if (bus_reset) begin
      cfg_d = 1'b0;
      adr_d = 1'b0;
    end else if (accept) begin
      cfg_d = wr_cfg;
      adr_d = ~wr_cfg;
    end
  end

  always_comb begin
    cnt_en = accept | busy_o;
    if (accept) cnt_d = CNT_LOAD;
    else        cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cfg_q <= 1'b0;
      adr_q <= 1'b0;
    end else if (st_en) begin
      cfg_q <= cfg_d;
      adr_q <= adr_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign state_o[ST_CFG_BIT] = cfg_q;
  assign state_o[ST_ADR_BIT] = adr_q;
  assign state_o[ST_DEF_BIT] = ~(cfg_q | adr_q);

  AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot(state_o)); // R2
  AST_WR_CFG: assert property (@(posedge clk) disable iff (!srst_n)
    accept && !bus_reset && wr_cfg |=> state_o == DS_CONFIGURED); // R3
  AST_WR_ADR: assert property (@(posedge clk) disable iff (!srst_n)
    accept && !bus_reset && !wr_cfg |=> state_o == DS_ADDRESSED); // R4
  AST_LOCK_START: assert property (@(posedge clk) disable iff (!srst_n)
    wr_req && !busy_o |=> busy_o); // R5
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!srst_n)
    busy_o && !bus_reset |=> $stable(state_o)); // R5
  AST_BUSRST_DEF: assert property (@(posedge clk) disable iff (!srst_n)
    bus_reset |=> state_o == DS_DEFAULT); // R10
endmodule

// File: rtl/usb_stat_irq.sv
module usb_stat_irq (
  input  logic clk,
  input  logic srst_n,
  input  logic wr_req,
  input  logic wr_en_val,
  input  logic wr_clr,
  input  logic setup,
  input  logic bus_reset,
  input  logic early,
  output logic en_o,
  output logic pend_o
);
  logic en_q, en_d, en_ce;
  logic pend_q, pend_d, pend_ce;
  logic pend_set;

  assign pend_set = en_q & early;

  always_comb begin
    en_ce = setup | wr_req;
    en_d  = setup ? 1'b0 : wr_en_val;
  end

  always_comb begin
    pend_ce = bus_reset | pend_set | (wr_req & wr_clr);
    if (bus_reset)     pend_d = 1'b0;
    else if (pend_set) pend_d = 1'b1;
    else               pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)    en_q <= 1'b0;
    else if (en_ce) en_q <= en_d;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)      pend_q <= 1'b0;
    else if (pend_ce) pend_q <= pend_d;
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;

  AST_EN_WRITE: assert property (@(posedge clk) disable iff (!srst_n)
    wr_req && !setup |=> en_o == $past(wr_en_val)); // R6
  AST_SETUP_DISARM: assert property (@(posedge clk) disable iff (!srst_n)
    setup |=> !en_o); // R7
  AST_PEND_SET: assert property (@(posedge clk) disable iff (!srst_n)
    en_o && early && !bus_reset |=> pend_o); // R8
  AST_PEND_CLR: assert property (@(posedge clk) disable iff (!srst_n)
    wr_req && wr_clr && !(en_o && early) |=> !pend_o); // R9
  AST_BUSRST_PEND: assert property (@(posedge clk) disable iff (!srst_n)
    bus_reset |=> !pend_o); // R10
endmodule

// File: rtl/usb_devstate_ctl.sv
module usb_devstate_ctl
  import usb_devstate_pkg::*;
#(
  parameter int unsigned LOCK_CYCLES = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_addr,
  input  logic             bus_wr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic             ev_setup,
  input  logic             ev_bus_reset,
  input  logic             ev_status_early,
  output logic [ST_W-1:0]  dev_state,
  output logic             wr_busy,
  output logic             irq
);
  logic srst_n;
  logic wr_state, wr_intctl;
  logic int_en, int_pend;
  logic [ST_W-1:0] st;

  assign wr_state  = bus_wr & (reg_sel_e'(bus_addr) == SEL_STATE);
  assign wr_intctl = bus_wr & (reg_sel_e'(bus_addr) == SEL_INTCTL);

  usb_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  usb_state_reg #(.LOCK_CYCLES(LOCK_CYCLES)) u_state_reg (
    .clk       (clk),
    .srst_n    (srst_n),
    .wr_req    (wr_state),
    .wr_cfg    (bus_wdata[ST_CFG_BIT]),
    .bus_reset (ev_bus_reset),
    .state_o   (st),
    .busy_o    (wr_busy)
  );

  usb_stat_irq u_stat_irq (
    .clk       (clk),
    .srst_n    (srst_n),
    .wr_req    (wr_intctl),
    .wr_en_val (bus_wdata[IC_EN_BIT]),
    .wr_clr    (bus_wdata[IC_PEND_BIT]),
    .setup     (ev_setup),
    .bus_reset (ev_bus_reset),
    .early     (ev_status_early),
    .en_o      (int_en),
    .pend_o    (int_pend)
  );

  always_comb begin
    bus_rdata = '0;
    if (reg_sel_e'(bus_addr) == SEL_STATE) begin
      bus_rdata[ST_W-1:0] = st;
    end else begin
      bus_rdata[IC_EN_BIT]   = int_en;
      bus_rdata[IC_PEND_BIT] = int_pend;
    end
  end

  assign dev_state = st;
  assign irq       = int_pend;

  AST_IRQ_MIRROR: assert property (@(posedge clk) disable iff (!srst_n)
    bus_addr |-> bus_rdata[IC_PEND_BIT] == irq); // R8
  AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!srst_n)
    !bus_addr |-> bus_rdata[REG_W-1:ST_W] == '0); // R2
endmodule

// File: tb/usb_devstate_ctl_bench.sv
module usb_devstate_ctl_bench;
  localparam int LOCK = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_addr = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       ev_setup = 1'b0;
  logic       ev_bus_reset = 1'b0;
  logic       ev_status_early = 1'b0;
  logic [2:0] dev_state;
  logic       wr_busy;
  logic       irq;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  // reference model state
  logic m_cfg = 1'b0, m_adr = 1'b0, m_en = 1'b0, m_pend = 1'b0;
  int   m_cnt = 0;

  always #2 clk = ~clk;

  usb_devstate_ctl #(.LOCK_CYCLES(LOCK)) u_usb_devstate_ctl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_setup(ev_setup),
    .ev_bus_reset(ev_bus_reset), .ev_status_early(ev_status_early),
    .dev_state(dev_state), .wr_busy(wr_busy), .irq(irq)
  );

  function automatic logic [2:0] exp_state();
    return {m_cfg, m_adr, ~(m_cfg | m_adr)};
  endfunction

  function automatic logic [7:0] exp_rd(input logic a);
    if (!a) return {5'b0, exp_state()};
    return {m_pend, 6'b0, m_en};
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic check_all(input string scen);
    chk({scen, " R2 dev_state"}, dev_state, exp_state());
    chk({scen, " R5 wr_busy"}, wr_busy, (m_cnt != 0));
    chk({scen, " R8 irq"}, irq, m_pend);
    chk({scen, bus_addr ? " R6 rdata" : " R2 rdata"}, bus_rdata, exp_rd(bus_addr));
  endtask

  task automatic step(input string scen, input logic wr, input logic a,
                      input logic [7:0] wd, input logic su, input logic br,
                      input logic er);
    logic acc;
    logic n_en, n_pend;
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = wd;
    ev_setup = su; ev_bus_reset = br; ev_status_early = er;
    @(posedge clk);
    acc = wr && !a && (m_cnt == 0);
    n_en = su ? 1'b0 : ((wr && a) ? wd[0] : m_en);
    if (br)                n_pend = 1'b0;
    else if (m_en && er)   n_pend = 1'b1;
    else if (wr && a && wd[7]) n_pend = 1'b0;
    else                   n_pend = m_pend;
    if (br) begin m_cfg = 1'b0; m_adr = 1'b0; end
    else if (acc) begin m_cfg = wd[2]; m_adr = ~wd[2]; end
    m_cnt = acc ? LOCK : ((m_cnt > 0) ? m_cnt - 1 : 0);
    m_en = n_en;
    m_pend = n_pend;
    #1;
    check_all(scen);
  endtask

  task automatic idle(input string scen, input int n);
    for (int i = 0; i < n; i++) step(scen, 1'b0, i[0], 8'h00, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc >= 100000) begin
        bad++;
        $display("FAIL watchdog expired cycles=%0d limit=%0d", cyc, 100000);
        finish_run();
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state at both addresses
    bus_addr = 1'b0; #1;
    chk("R1 dev_state", dev_state, 3'b001);
    chk("R1 state rd", bus_rdata, 8'h01);
    chk("R1 busy", wr_busy, 0);
    chk("R1 irq", irq, 0);
    bus_addr = 1'b1; #1;
    chk("R1 intctl rd", bus_rdata, 8'h00);

    // R3: configured write, then R5 lockout with writes ignored
    step("R3 cfg", 1'b1, 1'b0, 8'h06, 1'b0, 1'b0, 1'b0);
    chk("R3 configured", dev_state, 3'b100);
    for (int i = 0; i < LOCK; i++)
      step("R5 locked", 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    chk("R5 held configured", dev_state, 3'b100);
    // R4: bit2=0 gives Addressed regardless of bits 1,0
    step("R4 adr", 1'b1, 1'b0, 8'h01, 1'b0, 1'b0, 1'b0);
    chk("R4 addressed", dev_state, 3'b010);
    idle("R5 drain", LOCK);
    chk("R5 busy off", wr_busy, 0);

    // R6/R8: enable, early event, pending
    step("R6 en", 1'b1, 1'b1, 8'h01, 1'b0, 1'b0, 1'b0);
    step("R8 early", 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1);
    chk("R8 irq set", irq, 1);
    // R9: clear collides with early -> stays set; then clear alone
    step("R9 clr vs early", 1'b1, 1'b1, 8'h81, 1'b0, 1'b0, 1'b1);
    chk("R9 early wins", irq, 1);
    step("R9 clr", 1'b1, 1'b1, 8'h81, 1'b0, 1'b0, 1'b0);
    chk("R9 cleared", irq, 0);
    // R7: setup beats same-cycle enable write
    step("R7 setup vs wr", 1'b1, 1'b1, 8'h01, 1'b1, 1'b0, 1'b0);
    chk("R7 en cleared", bus_rdata[0], 0);
    step("R7 early ignored", 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1);
    chk("R7 no pend", irq, 0);
    // R10: bus reset beats state write, clears pending, keeps enable
    step("R10 en", 1'b1, 1'b1, 8'h01, 1'b0, 1'b0, 1'b0);
    step("R10 pend", 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1);
    step("R10 br vs wr", 1'b1, 1'b0, 8'h04, 1'b0, 1'b1, 1'b0);
    chk("R10 default", dev_state, 3'b001);
    chk("R10 pend clr", irq, 0);
    chk("R10 lock started", wr_busy, 1);
    step("R10 en kept", 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0);
    chk("R10 en kept", bus_rdata[0], 1);

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      step("rand", ($urandom % 3) == 0, $urandom % 2, 8'($urandom),
           ($urandom % 8) == 0, ($urandom % 32) == 0, ($urandom % 4) == 0);
    end
    finish_run();
  end
endmodule